// File: doc/BRIEF.md
# Fault Snapshot Log Sequencer

This block records the state of a supervisory monitor at the instant a fault is raised. In the trigger cycle it freezes a mixed set of live values into a shadow buffer. The set holds three 8-bit status registers, eight voltage conversion results, three 10-bit temperature results and one current-sense byte. It then copies the buffer, one byte per address, into a 15-byte region of a nonvolatile memory through a request/acknowledge write port.

The first voltage channel and the current-sense value are stored whole as bytes. Voltage channels two to eight and the three temperatures are reduced to their eight most significant bits. Once a log has been written, the sequencer locks and ignores further triggers until a clear pulse re-arms it.

The controller has four states:
- `ST_IDLE`: armed. It goes to `ST_WRITE` on a trigger with enable high, and captures the buffer in that cycle.
- `ST_WRITE`: a byte is being offered. It stays there until acknowledged, and goes to `ST_FIN` on the acknowledge of the last byte.
- `ST_FIN`: the done pulse. It goes unconditionally to `ST_HOLD`.
- `ST_HOLD`: locked. It returns to `ST_IDLE` on a clear pulse.

Top module: `fsnap_logger`

## Requirements
- R1: While reset is low, and in the first cycle after it, `busy`, `done` and `mem_wr` are all low.
- R2: One log makes exactly 15 writes, to addresses 80h, 81h, … 8Eh in ascending order, one byte per address.
- R3: Addresses 80h, 81h and 82h receive status registers 0, 1 and 2. Register k is `stat_in[8k+7:8k]`.
- R4: Address 83h receives `vch1_in` unchanged. Addresses 84h to 8Ah receive channels 2 to 8, where channel k+2 is the top 8 bits of `vchx_in[VW*k +: VW]`.
- R5: Addresses 8Bh, 8Ch and 8Dh receive the top 8 bits of the internal, remote-1 and remote-2 temperatures. These are `temp_in` slices 0, 1 and 2 of TW bits each.
- R6: Address 8Eh receives `isns_in` unchanged.
- R7: All stored bytes equal the input values present on the trigger cycle. Later input changes have no effect.
- R8: While `mem_wr` is high without `mem_ack`, the address and data hold steady. A write completes on a cycle where both are high, and the next byte is offered in the following cycle.
- R9: `busy` is high from the cycle after the trigger until the last byte is acknowledged. `done` is then high for exactly one cycle, with `busy` low.
- R10: After a log completes, triggers cause no writes until `clr` is pulsed. After the pulse, a trigger starts a new log.
- R11: A trigger while `en` is low causes no writes and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Logging enable |
| trig | input | 1 | Fault trigger pulse |
| clr | input | 1 | Re-arm pulse after a completed log |
| stat_in | input | 24 | Three status registers, register 0 in the low byte |
| vch1_in | input | 8 | First voltage channel result |
| vchx_in | input | 7*VW | Voltage channels 2..8, channel 2 lowest |
| temp_in | input | 3*TW | Internal, remote-1, remote-2 temperatures, internal lowest |
| isns_in | input | 8 | Current-sense result |
| mem_ack | input | 1 | Memory write acknowledge |
| mem_addr | output | AW | Memory byte address |
| mem_data | output | 8 | Memory write data |
| mem_wr | output | 1 | Write request, held until acknowledged |
| busy | output | 1 | Log write in progress |
| done | output | 1 | One-cycle pulse when the log is complete |

## Verification
The assertions assume that all inputs are known after reset. They also assume the memory asserts `mem_ack` only while a write request is pending, because the handshake properties treat an acknowledge as the completion of the offered byte. The stimulus keeps to this by drawing each cycle's acknowledge at random, gated by the current `mem_wr`. It changes the monitored inputs every cycle while a log is written, and issues trigger and clear pulses only from the falling edge.

// File: rtl/fsnap_pkg.sv
package fsnap_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FIN   = 2'd2,
        ST_HOLD  = 2'd3
    } fsnap_state_e;

endpackage

// File: rtl/fsnap_capture.sv
module fsnap_capture
    import fsnap_pkg::*;
#(
    parameter int N_STAT = 3,
    parameter int N_VCH  = 8,
    parameter int VW     = 10,
    parameter int N_TEMP = 3,
    parameter int TW     = 10,
    parameter int NB     = N_STAT + N_VCH + N_TEMP + 1,
    parameter int IDXW   = $clog2(NB)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [N_STAT*BYTE_W-1:0] stat_in,
    input  logic [BYTE_W-1:0]       vch1_in,
    input  logic [(N_VCH-1)*VW-1:0] vchx_in,
    input  logic [N_TEMP*TW-1:0]    temp_in,
    input  logic [BYTE_W-1:0]       isns_in,
    input  logic [IDXW-1:0]         sel_i,
    output logic [BYTE_W-1:0]       byte_o
);

    localparam int V1_POS   = N_STAT;
    localparam int VX_POS   = N_STAT + 1;
    localparam int TEMP_POS = N_STAT + N_VCH;
    localparam int ISNS_POS = NB - 1;

    logic [NB*BYTE_W-1:0] live;
    logic [NB*BYTE_W-1:0] shadow;

    // Byte order of the log: status, channel 1, channels 2..N, temperatures, current
    genvar g;
    generate
        for (g = 0; g < N_STAT; g++) begin : g_stat
            assign live[(g)*BYTE_W +: BYTE_W] = stat_in[g*BYTE_W +: BYTE_W];
        end
        for (g = 0; g < N_VCH - 1; g++) begin : g_vch
            assign live[(VX_POS+g)*BYTE_W +: BYTE_W] = vchx_in[g*VW + VW - BYTE_W +: BYTE_W];
        end
        for (g = 0; g < N_TEMP; g++) begin : g_temp
            assign live[(TEMP_POS+g)*BYTE_W +: BYTE_W] = temp_in[g*TW + TW - BYTE_W +: BYTE_W];
        end
    endgenerate

    assign live[V1_POS*BYTE_W +: BYTE_W]   = vch1_in;
    assign live[ISNS_POS*BYTE_W +: BYTE_W] = isns_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (load_i) begin
            shadow <= live;
        end
    end

    always_comb begin
        byte_o = '0;
        if (32'(sel_i) < NB) begin
            byte_o = shadow[sel_i*BYTE_W +: BYTE_W];
        end
    end

    // R7: the frozen copy never moves except on a capture
    a_r7_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(shadow));

endmodule

// File: rtl/fsnap_ctrl.sv
module fsnap_ctrl
    import fsnap_pkg::*;
#(
    parameter int NB   = 15,
    parameter int IDXW = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            trig,
    input  logic            clr,
    input  logic            mem_ack,
    output logic            load_o,
    output logic [IDXW-1:0] idx_o,
    output logic            mem_wr_o,
    output logic            busy_o,
    output logic            done_o
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NB - 1);

    fsnap_state_e state, state_nx;
    logic [IDXW-1:0] idx_nx;
    logic            start;
    logic            wr_done;

    assign start   = en && trig;
    assign wr_done = (state == ST_WRITE) && mem_ack;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx_o <= '0;
        end else begin
            state <= state_nx;
            idx_o <= idx_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        idx_nx   = idx_o;
        unique case (state)
            ST_IDLE: begin
                idx_nx = '0;
                if (start) state_nx = ST_WRITE;
            end
            ST_WRITE: begin
                if (wr_done) begin
                    if (idx_o == LAST_IDX) begin
                        state_nx = ST_FIN;
                    end else begin
                        idx_nx = idx_o + 1'b1;
                    end
                end
            end
            ST_FIN: begin
                state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (clr) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o   = 1'b0;
        mem_wr_o = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state)
            ST_IDLE:  load_o = start;
            ST_WRITE: begin
                mem_wr_o = 1'b1;
                busy_o   = 1'b1;
            end
            ST_FIN:   done_o = 1'b1;
            ST_HOLD:  ;
            default:  ;
        endcase
    end

    // R8: an unanswered request keeps its slot
    a_r8_hold_slot: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o && !mem_ack |=> mem_wr_o && $stable(idx_o));

    // R9: done lasts one cycle and follows the final acknowledged write
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o) && $past(mem_ack));

    // R10: a finished log stays locked until clear
    a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) && !clr |=> (state == ST_HOLD));

    // R11: no start without enable
    a_r11_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && !en |=> (state == ST_IDLE) && !busy_o);

endmodule

// File: rtl/fsnap_logger.sv
module fsnap_logger
    import fsnap_pkg::*;
#(
    parameter int          N_STAT    = 3,
    parameter int          N_VCH     = 8,
    parameter int          VW        = 10,
    parameter int          N_TEMP    = 3,
    parameter int          TW        = 10,
    parameter int          AW        = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     trig,
    input  logic                     clr,
    input  logic [N_STAT*BYTE_W-1:0] stat_in,
    input  logic [BYTE_W-1:0]        vch1_in,
    input  logic [(N_VCH-1)*VW-1:0]  vchx_in,
    input  logic [N_TEMP*TW-1:0]     temp_in,
    input  logic [BYTE_W-1:0]        isns_in,
    input  logic                     mem_ack,
    output logic [AW-1:0]            mem_addr,
    output logic [BYTE_W-1:0]        mem_data,
    output logic                     mem_wr,
    output logic                     busy,
    output logic                     done
);

    localparam int NB   = N_STAT + N_VCH + N_TEMP + 1;
    localparam int IDXW = $clog2(NB);

    logic            load;
    logic [IDXW-1:0] idx;

    fsnap_ctrl #(
        .NB   (NB),
        .IDXW (IDXW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .trig     (trig),
        .clr      (clr),
        .mem_ack  (mem_ack),
        .load_o   (load),
        .idx_o    (idx),
        .mem_wr_o (mem_wr),
        .busy_o   (busy),
        .done_o   (done)
    );

    fsnap_capture #(
        .N_STAT (N_STAT),
        .N_VCH  (N_VCH),
        .VW     (VW),
        .N_TEMP (N_TEMP),
        .TW     (TW),
        .NB     (NB),
        .IDXW   (IDXW)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .stat_in (stat_in),
        .vch1_in (vch1_in),
        .vchx_in (vchx_in),
        .temp_in (temp_in),
        .isns_in (isns_in),
        .sel_i   (idx),
        .byte_o  (mem_data)
    );

    assign mem_addr = AW'(BASE_ADDR) + AW'(idx);

    // R2: every request lands inside the log window
    a_r2_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr >= AW'(BASE_ADDR)) && (mem_addr <= AW'(BASE_ADDR) + AW'(NB - 1)));

    // R2: an acknowledged non-final write is followed by the next address
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && mem_ack && (mem_addr != AW'(BASE_ADDR) + AW'(NB - 1))
        |=> mem_wr && (mem_addr == $past(mem_addr) + 1'b1));

    // R8: data offered with a pending request does not change
    a_r8_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && !mem_ack |=> $stable(mem_data) && $stable(mem_addr));

endmodule

// File: tb/sim_fsnap_logger.sv
module sim_fsnap_logger;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, en, trig, clr, mem_ack;
    logic [23:0] stat_in;
    logic [7:0]  vch1_in, isns_in;
    logic [69:0] vchx_in;
    logic [29:0] temp_in;
    logic [7:0]  mem_addr, mem_data;
    logic        mem_wr, busy, done;

    fsnap_logger u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .clr(clr),
        .stat_in(stat_in), .vch1_in(vch1_in), .vchx_in(vchx_in),
        .temp_in(temp_in), .isns_in(isns_in), .mem_ack(mem_ack),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_wr(mem_wr),
        .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    int wcnt  = 0;
    int ack_pct = 50;
    logic [7:0] memv [0:255];
    logic       prev_wr = 1'b0, prev_done = 1'b0;
    logic [7:0] prev_addr = '0, prev_data = '0;

    logic [23:0] s_stat;
    logic [7:0]  s_v1, s_is;
    logic [69:0] s_vx;
    logic [29:0] s_t;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i);
        if (i < 3)       return s_stat[i*8 +: 8];
        else if (i == 3) return s_v1;
        else if (i < 11) return s_vx[(i-4)*10 + 2 +: 8];
        else if (i < 14) return s_t[(i-11)*10 + 2 +: 8];
        else             return s_is;
    endfunction

    function automatic string req_of(input int i);
        if (i < 3)       return "R3";
        else if (i < 11) return "R4";
        else if (i < 14) return "R5";
        else             return "R6";
    endfunction

    task automatic set_inputs(input int mode);
        if (mode == 1) begin
            stat_in = '1; vch1_in = '1; vchx_in = '1; temp_in = '1; isns_in = '1;
        end else if (mode == 2) begin
            stat_in = '0; vch1_in = '0; vchx_in = '0; temp_in = '0; isns_in = '0;
        end else begin
            stat_in = 24'($urandom);
            vch1_in = 8'($urandom);
            vchx_in = {6'($urandom), $urandom, $urandom};
            temp_in = 30'($urandom);
            isns_in = 8'($urandom);
        end
    endtask

    // memory model, handshake monitor and acknowledge generator
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_wr && mem_ack) begin
                memv[prev_addr] = prev_data;
                chk(prev_addr == 8'(8'h80 + wcnt), "R2", prev_addr, 8'h80 + wcnt);
                wcnt++;
            end else if (prev_wr) begin
                chk(mem_wr && mem_addr == prev_addr && mem_data == prev_data, "R8",
                    {mem_addr, mem_data}, {prev_addr, prev_data});
            end
            if (prev_done) chk(!done, "R9", done, 0);
        end
        prev_wr   = mem_wr;
        prev_addr = mem_addr;
        prev_data = mem_data;
        prev_done = done;
        mem_ack   = mem_wr && (($urandom % 100) < 32'(ack_pct));
    end

    task automatic fire(input bit en_v, input int mode);
        @(negedge clk);
        set_inputs(mode);
        en = en_v; trig = 1'b1;
        s_stat = stat_in; s_v1 = vch1_in; s_vx = vchx_in; s_t = temp_in; s_is = isns_in;
        @(negedge clk);
        trig = 1'b0;
        set_inputs(0);
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic run_log(input int mode);
        int cyc = 0;
        wcnt = 0;
        fire(1'b1, mode);
        chk(busy, "R9", busy, 1);
        while (!done && cyc < 1000) begin
            if (!busy) begin
                chk(0, "R9", busy, 1);
                break;
            end
            @(negedge clk);
            set_inputs(0);   // R7: inputs keep moving while the log is written
            cyc++;
        end
        chk(done && !busy, "R9", {done, busy}, 2'b10);
        @(negedge clk);
        chk(wcnt == 15, "R2", wcnt, 15);
        for (int i = 0; i < 15; i++) begin
            chk(memv[8'h80 + i] == exp_byte(i), req_of(i), memv[8'h80 + i], exp_byte(i));
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; en = 1'b0; trig = 1'b0; clr = 1'b0; mem_ack = 1'b0;
        set_inputs(2);
        for (int i = 0; i < 256; i++) memv[i] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_wr, "R1", {busy, done, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_wr, "R1", {busy, done, mem_wr}, 0);

        // first log with random data, R7 checked through run_log
        run_log(0);

        // R10: locked after completion
        wcnt = 0;
        fire(1'b1, 0);
        repeat (20) @(negedge clk);
        chk(wcnt == 0 && !busy, "R10", wcnt, 0);
        pulse_clr();

        // R11: trigger with enable low
        wcnt = 0;
        fire(1'b0, 0);
        repeat (20) @(negedge clk);
        chk(wcnt == 0 && !busy, "R11", wcnt, 0);

        // R10: after clear a new log runs; directed corner values
        ack_pct = 100;
        run_log(1);
        pulse_clr();
        ack_pct = 15;
        run_log(2);
        pulse_clr();

        // random logs with varied acknowledge latency
        for (int k = 0; k < 6; k++) begin
            ack_pct = 10 + int'($urandom % 91);
            run_log(0);
            pulse_clr();
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule